// File: doc/BRIEF.md
# Masked-Write GPIO Bank Controller

This block holds the direction and output-value state for several banks of general-purpose pins. The default is four banks of sixteen pins each. Software reaches the block through a plain register write port: an address, a 32-bit data word and a one-cycle strobe. Each direction or value write carries its own per-bit mask in the upper half-word. Only the selected pins change, so software never needs a read-modify-write sequence.

A separate debug-enable register holds one bit per bank. While a bank's bit is set, that bank's output-enable and output-value pins come straight from an internal debug bus instead of the stored registers. The stored contents are kept intact, and writes to them continue to land. A readback port returns the pin inputs of every bank after a two-flop synchronizer. The pads are modelled as separate output-enable and output-value vectors. Bank b occupies bits [16*b+15 : 16*b] of every flattened pin vector.

Top module: `gpio_mask_bank`

## Requirements
- R1: After reset every direction register, value register and debug-enable bit is zero, so `padOe`, `padOut` and `pinSync` are all zero.
- R2: A write to address b (0 to 3) updates the direction register of bank b. Each bit whose mask bit (`wrData[31:16]`) is 1 takes the matching bit of `wrData[15:0]`. Every other bit keeps its value. The result is visible on `padOe` from the clock edge that samples the write.
- R3: A write to address 4+b (b = 0 to 3) updates the value register of bank b under the same masking rule. The result is visible on `padOut`.
- R4: A write changes only the addressed register of the addressed bank. All other banks and registers are unchanged.
- R5: A write to address 8 loads the debug-enable register from `wrData[3:0]`, with bit b belonging to bank b; no mask applies. While bit b is set, bank b of `padOe` and `padOut` follow bank b of `dbgOe` and `dbgOut` combinationally.
- R6: The debug override leaves the stored registers untouched. Writes made during the override still update them. Clearing the enable bit makes the bank show the stored contents again.
- R7: `pinSync` equals `padIn` delayed by exactly two clock edges.
- R8: Writes to addresses 9 to 15 change no state.
- R9: A direction or value write whose mask half-word is zero changes no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrAddr | input | 4 | Register address |
| wrData | input | 32 | Mask in [31:16], new bits in [15:0] |
| dbgOe | input | 64 | Debug direction source, 16 bits per bank |
| dbgOut | input | 64 | Debug value source, 16 bits per bank |
| padIn | input | 64 | Asynchronous pin inputs |
| padOe | output | 64 | Pin output enables (1 = drive toward the board) |
| padOut | output | 64 | Pin output values |
| pinSync | output | 64 | Synchronized pin readback |

## Verification
The assertions assume that `wrEn`, `wrAddr` and `wrData` are stable around each rising edge. They also assume that a register changes only on a cycle in which the decoder raises its strobe. With that in place, masked-off bits never move and at most one register strobe is active at a time. The bench changes every input at the falling clock edge and keeps `wrEn` high for exactly one cycle. It gives `padIn` and the debug buses values that differ from bank to bank, so a bank swap or a missing mask shows on the pins.

// File: rtl/gpio_mask_bank_pkg.sv
package gpio_mask_bank_pkg;
  localparam int GB_BANKS = 4;
  localparam int GB_WIDTH = 16;
  localparam int GB_PINS  = GB_BANKS * GB_WIDTH;

  // strobes from address decode to the register datapath
  typedef struct packed {
    logic [GB_BANKS-1:0] dirWe;
    logic [GB_BANKS-1:0] valWe;
    logic                dbgWe;
    logic [GB_WIDTH-1:0] mask;
    logic [GB_WIDTH-1:0] bits;
  } gbStrobe_t;
endpackage

// File: rtl/gpio_wr_decode.sv
module gpio_wr_decode
  import gpio_mask_bank_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [2*GB_WIDTH-1:0] wrData,
  output gbStrobe_t           strb
);
  localparam logic [ADDR_W-1:0] VAL_BASE = ADDR_W'(GB_BANKS);
  localparam logic [ADDR_W-1:0] DBG_ADDR = ADDR_W'(2 * GB_BANKS);

  always_comb begin
    strb       = '0;
    strb.mask  = wrData[2*GB_WIDTH-1:GB_WIDTH];
    strb.bits  = wrData[GB_WIDTH-1:0];
    for (int i = 0; i < GB_BANKS; i++) begin
      strb.dirWe[i] = wrEn && (wrAddr == ADDR_W'(i));
      strb.valWe[i] = wrEn && (wrAddr == VAL_BASE + ADDR_W'(i));
    end
    strb.dbgWe = wrEn && (wrAddr == DBG_ADDR);
  end

  // R4: one register at most per write
  assert_single_target_R4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.dirWe, strb.valWe, strb.dbgWe}));

  // R8: unmapped addresses raise no strobe
  assert_unmapped_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (wrAddr > DBG_ADDR)) |-> (strb.dirWe == '0 && strb.valWe == '0 && !strb.dbgWe));
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_mask_bank_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  gbStrobe_t          strb,
  input  logic [GB_PINS-1:0] dbgOe,
  input  logic [GB_PINS-1:0] dbgOut,
  input  logic [GB_PINS-1:0] padIn,
  output logic [GB_PINS-1:0] padOe,
  output logic [GB_PINS-1:0] padOut,
  output logic [GB_PINS-1:0] pinSync
);
  logic [GB_BANKS-1:0][GB_WIDTH-1:0] dirReg;
  logic [GB_BANKS-1:0][GB_WIDTH-1:0] valReg;
  logic [GB_BANKS-1:0]               dbgEn;

  always_ff @(posedge clk) begin
    if (!rstN) dbgEn <= '0;
    else if (strb.dbgWe) dbgEn <= strb.bits[GB_BANKS-1:0];
  end

  for (genvar b = 0; b < GB_BANKS; b++) begin : gBank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dirReg[b] <= '0;
        valReg[b] <= '0;
      end else begin
        if (strb.dirWe[b]) dirReg[b] <= (dirReg[b] & ~strb.mask) | (strb.bits & strb.mask);
        if (strb.valWe[b]) valReg[b] <= (valReg[b] & ~strb.mask) | (strb.bits & strb.mask);
      end
    end

    assign padOe[b*GB_WIDTH +: GB_WIDTH]  = dbgEn[b] ? dbgOe[b*GB_WIDTH +: GB_WIDTH]  : dirReg[b];
    assign padOut[b*GB_WIDTH +: GB_WIDTH] = dbgEn[b] ? dbgOut[b*GB_WIDTH +: GB_WIDTH] : valReg[b];

    // R2/R9: masked-off direction bits never move
    assert_dir_mask_R2: assert property (@(posedge clk) disable iff (!rstN)
      strb.dirWe[b] |=> (((dirReg[b] ^ $past(dirReg[b])) & ~$past(strb.mask)) == '0));
    // R3/R9: masked-off value bits never move
    assert_val_mask_R3: assert property (@(posedge clk) disable iff (!rstN)
      strb.valWe[b] |=> (((valReg[b] ^ $past(valReg[b])) & ~$past(strb.mask)) == '0));
    // R4: untargeted registers hold
    assert_dir_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
      !strb.dirWe[b] |=> $stable(dirReg[b]));
    assert_val_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
      !strb.valWe[b] |=> $stable(valReg[b]));
  end

  // R7: synchronizer chain
  logic [SYNC_STAGES-1:0][GB_PINS-1:0] syncQ;
  always_ff @(posedge clk) begin
    if (!rstN) syncQ <= '0;
    else syncQ <= {syncQ[SYNC_STAGES-2:0], padIn};
  end
  assign pinSync = syncQ[SYNC_STAGES-1];

  // R5: debug enable changes only on its strobe
  assert_dbg_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.dbgWe |=> $stable(dbgEn));
endmodule

// File: rtl/gpio_mask_bank.sv
module gpio_mask_bank
  import gpio_mask_bank_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [2*GB_WIDTH-1:0] wrData,
  input  logic [GB_PINS-1:0]    dbgOe,
  input  logic [GB_PINS-1:0]    dbgOut,
  input  logic [GB_PINS-1:0]    padIn,
  output logic [GB_PINS-1:0]    padOe,
  output logic [GB_PINS-1:0]    padOut,
  output logic [GB_PINS-1:0]    pinSync
);
  gbStrobe_t strb;

  gpio_wr_decode #(.ADDR_W(ADDR_W)) uDecode (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .strb(strb)
  );

  gpio_bank_regs #(.SYNC_STAGES(SYNC_STAGES)) uRegs (
    .clk(clk), .rstN(rstN), .strb(strb), .dbgOe(dbgOe), .dbgOut(dbgOut),
    .padIn(padIn), .padOe(padOe), .padOut(padOut), .pinSync(pinSync)
  );
endmodule

// File: tb/gpio_mask_bank_test.sv
module gpio_mask_bank_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [63:0] dbgOe = '0, dbgOut = '0, padIn = '0;
  logic [63:0] padOe, padOut, pinSync;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  gpio_mask_bank uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .dbgOe(dbgOe), .dbgOut(dbgOut), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .pinSync(pinSync)
  );

  // {addr, data, expected padOe, expected padOut}
  localparam logic [163:0] VEC [8] = '{
    {4'd0, 32'hFFFF_A5A5, 64'h0000_0000_0000_A5A5, 64'h0},                   // R2
    {4'd0, 32'h00F0_0F0F, 64'h0000_0000_0000_A505, 64'h0},                   // R2 partial mask
    {4'd5, 32'hFFFF_1234, 64'h0000_0000_0000_A505, 64'h0000_0000_1234_0000}, // R3 R4
    {4'd5, 32'h0F00_FFFF, 64'h0000_0000_0000_A505, 64'h0000_0000_1F34_0000}, // R3
    {4'd9, 32'hFFFF_FFFF, 64'h0000_0000_0000_A505, 64'h0000_0000_1F34_0000}, // R8
    {4'd3, 32'h0000_FFFF, 64'h0000_0000_0000_A505, 64'h0000_0000_1F34_0000}, // R9
    {4'd7, 32'hFFFF_8001, 64'h0000_0000_0000_A505, 64'h8001_0000_1F34_0000}, // R3 R4
    {4'd2, 32'hFF00_FFFF, 64'h0000_FF00_0000_A505, 64'h8001_0000_1F34_0000}  // R2 R4
  };
  localparam string VTAG [8] = '{"R2", "R2", "R3", "R3", "R8", "R9", "R3", "R4"};

  task automatic check64(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check64("R1 oe", padOe, 64'h0);
    check64("R1 out", padOut, 64'h0);
    check64("R1 sync", pinSync, 64'h0);

    for (int i = 0; i < 8; i++) begin
      regWrite(VEC[i][163:160], VEC[i][159:128]);
      check64(VTAG[i], padOe, VEC[i][127:64]);
      check64(VTAG[i], padOut, VEC[i][63:0]);
    end

    // R5 debug override on bank 1
    dbgOe  = 64'hAAAA_BBBB_CCCC_DDDD;
    dbgOut = 64'h1111_2222_3333_4444;
    regWrite(4'd8, 32'h0000_0002);
    check64("R5 oe", padOe, 64'h0000_FF00_CCCC_A505);
    check64("R5 out", padOut, 64'h8001_0000_3333_0000);
    dbgOe = 64'hAAAA_BBBB_5A5A_DDDD;
    #1;
    check64("R5 comb", padOe, 64'h0000_FF00_5A5A_A505);
    // R6 write while overridden
    regWrite(4'd5, 32'hFFFF_0F0F);
    check64("R6 during", padOut, 64'h8001_0000_3333_0000);
    regWrite(4'd8, 32'h0000_0000);
    check64("R6 oe back", padOe, 64'h0000_FF00_0000_A505);
    check64("R6 out back", padOut, 64'h8001_0000_0F0F_0000);

    // R7 two-edge synchronizer latency
    padIn = 64'hDEAD_BEEF_0123_4567;
    @(negedge clk);
    check64("R7 one edge", pinSync, 64'h0);
    @(negedge clk);
    check64("R7 two edges", pinSync, 64'hDEAD_BEEF_0123_4567);

    // R1 reset mid-run
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    dbgOe = '0; dbgOut = '0;
    check64("R1 re oe", padOe, 64'h0);
    check64("R1 re out", padOut, 64'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule